// File: doc/BRIEF.md
# I2C Master Byte Receiver

This block is the receive side of an I2C bus master. After the address phase has been handled elsewhere, a host selects master receive mode through a four-register interface. From then on, the host paces reception by reading the data register. The first read is a dummy read whose only job is to start the first byte. Each later read hands over one received byte and lets the engine clock in the next one. SCL comes from a fixed divider: each half period of SCL lasts `HALF_DIV` core clocks. SDA is sampled at the end of every high phase, with the most significant bit first. In the ninth clock the engine drives the acknowledge level that the host chose.

To finish a transfer, the host sets a hold control together with NACK. It then reads the next-to-last byte. The engine receives exactly one more byte, answers it with NACK, and keeps SCL low. The host then clears the stop-done flag and writes the bus register to request a stop condition. When the done flag rises, it reads the final byte and leaves master mode. For a single-byte transfer, the host sets hold and NACK in the same write that enters receive mode, and then makes the dummy read.

Register map (2-bit address, 8-bit data):
- 0 control: bit0 master, bit1 transmit, bit2 hold, bit3 NACK.
- 1 status: bit0 byte-ready, bit1 stop-done, bit2 transmit-end, bit3 transmit-empty.
- 2 data.
- 3 bus: bit0 busy, bit1 start/stop.

Top module: `i2c_byte_rx`

## Requirements
- R1: After reset, the status register reads 0x0C, the control register reads 0x00, the bus register reads 0x00, and both `sclO` and `sdaO` are 1 (released).
- R2: A control write that sets master=1 and transmit=0 while receive mode was off clears transmit-end (status bit2) and transmit-empty (status bit3). Setting master from 0 to 1 also sets busy (bus bit0).
- R3: After entering receive mode, SCL stays low and produces no rising edge until the first data-register read. That dummy read starts the first byte.
- R4: Byte-ready (status bit0) becomes visible 16*HALF_DIV+1 clocks after the clock edge that samples the starting read. The data register then returns the 8 bits sampled on SDA, most significant bit first.
- R5: In the ninth SCL clock, SDA is driven low when NACK (control bit3) is 0, and released when it is 1.
- R6: A data-register read clears byte-ready. While hold is 0, that read also starts the next byte.
- R7: While byte-ready is set and the data register has not been read, SCL stays low after the ninth clock, so no unread byte is overwritten.
- R8: With hold set, the first data read that follows starts exactly one more byte. Further reads start no SCL clocks until hold is cleared.
- R9: A bus-register write with bits[1:0]=00 while busy produces a stop condition: SDA rises while SCL is high, at least HALF_DIV clocks after SCL rose. It then sets stop-done (status bit1) and clears busy.
- R10: Writing 1 to status bit1 clears stop-done.
- R11: If a data read is sampled on the same edge that completes a byte, the read returns the previous byte, byte-ready stays set, and no further byte starts until the next read.
- R12: If hold and NACK are set in the write that enters receive mode, the dummy read yields exactly one byte, answered with NACK. That byte is readable after the stop condition.
- R13: Writing control 0x00 leaves master mode: both bus lines are released and control reads back 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (side effects on data register) |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data (combinational from address) |
| sdaIn | input | 1 | Sampled SDA line level |
| sclO | output | 1 | SCL level; 0 means pull low, 1 means release |
| sdaO | output | 1 | SDA level; 0 means pull low, 1 means release |

## Verification
Two events can land on the same clock edge: the host's data-register read and the completion of the eighth data bit. The bench places that read on the capture edge by counting clocks from the read that started the byte. It then checks three things: the read returns the previous byte, byte-ready stays set, and SCL makes no further rising edge until a later read.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_BUS  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_BIT_L, ST_BIT_H,
    ST_ACK_L, ST_ACK_H, ST_STOP_L, ST_STOP_H
  } rxState_t;

  typedef struct packed {
    logic shiftEn;
    logic capture;
    logic sclLow;
    logic sdaLow;
  } lineStrb_t;
endpackage

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import i2c_rx_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic                regRe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [BYTE_W-1:0]   regWdata,
  input  logic [BYTE_W-1:0]   rxByte,
  output logic [BYTE_W-1:0]   regRdata,
  output lineStrb_t           strb
);
  localparam int CNT_W = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic master, transmit, hold, nack, busy;
  logic rxFull, stopDone, txEnd, txEmpty;
  logic goPend, holdUsed, stopPend;
  rxState_t st;
  logic [CNT_W-1:0] halfCnt;
  logic [2:0] bitIdx;

  logic ctrlWr, statWr, busWr, dataRd;
  logic rxMode, rxActive, enterRx, halfDone, capture, grant, stopFinish, startByte, timed;

  assign ctrlWr     = regWe && (regAddr == ADDR_CTRL);
  assign statWr     = regWe && (regAddr == ADDR_STAT);
  assign busWr      = regWe && (regAddr == ADDR_BUS);
  assign dataRd     = regRe && (regAddr == ADDR_DATA);
  assign rxMode     = master && !transmit;
  assign rxActive   = rxMode && busy;
  assign enterRx    = ctrlWr && regWdata[0] && !regWdata[1] && !rxMode;
  assign halfDone   = (halfCnt == CNT_LAST);
  assign capture    = (st == ST_BIT_H) && halfDone && (bitIdx == 3'd0);
  assign grant      = dataRd && rxActive && !capture && (!hold || !holdUsed);
  assign stopFinish = (st == ST_STOP_H) && halfDone;
  assign startByte  = (st == ST_WAIT) && goPend && !stopPend;
  assign timed      = st inside {ST_BIT_L, ST_BIT_H, ST_ACK_L, ST_ACK_H, ST_STOP_L, ST_STOP_H};

  // host-visible registers and flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      master <= 1'b0; transmit <= 1'b0; hold <= 1'b0; nack <= 1'b0;
      busy <= 1'b0; rxFull <= 1'b0; stopDone <= 1'b0;
      txEnd <= 1'b1; txEmpty <= 1'b1;
      goPend <= 1'b0; holdUsed <= 1'b0; stopPend <= 1'b0;
    end else begin
      if (ctrlWr) begin
        master   <= regWdata[0];
        transmit <= regWdata[1];
        hold     <= regWdata[2];
        nack     <= regWdata[3];
      end
      if (enterRx) begin
        txEnd   <= 1'b0;
        txEmpty <= 1'b0;
      end
      if (stopFinish) busy <= 1'b0;
      else if (ctrlWr && regWdata[0] && !master) busy <= 1'b1;

      if (stopFinish || !busy) stopPend <= 1'b0;
      else if (busWr && (regWdata[1:0] == 2'b00)) stopPend <= 1'b1;

      if (stopFinish) stopDone <= 1'b1;
      else if (statWr && regWdata[1]) stopDone <= 1'b0;

      if (capture) rxFull <= 1'b1;
      else if (dataRd) rxFull <= 1'b0;

      if (capture || !rxActive) goPend <= 1'b0;
      else if (grant) goPend <= 1'b1;
      else if (startByte) goPend <= 1'b0;

      if (!hold) holdUsed <= 1'b0;
      else if (grant) holdUsed <= 1'b1;
    end
  end

  // bit sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= ST_IDLE; halfCnt <= '0; bitIdx <= 3'd7;
    end else if (!rxActive) begin
      st <= ST_IDLE; halfCnt <= '0;
    end else begin
      if (timed) halfCnt <= halfDone ? '0 : halfCnt + 1'b1;
      else halfCnt <= '0;
      unique case (st)
        ST_IDLE: st <= ST_WAIT;
        ST_WAIT: begin
          if (stopPend) st <= ST_STOP_L;
          else if (goPend) begin st <= ST_BIT_L; bitIdx <= 3'd7; end
        end
        ST_BIT_L: if (halfDone) st <= ST_BIT_H;
        ST_BIT_H: if (halfDone) begin
          if (bitIdx == 3'd0) st <= ST_ACK_L;
          else begin bitIdx <= bitIdx - 3'd1; st <= ST_BIT_L; end
        end
        ST_ACK_L:  if (halfDone) st <= ST_ACK_H;
        ST_ACK_H:  if (halfDone) st <= ST_WAIT;
        ST_STOP_L: if (halfDone) st <= ST_STOP_H;
        ST_STOP_H: if (halfDone) st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.shiftEn = (st == ST_BIT_H) && halfDone;
    strb.capture = capture;
    strb.sclLow  = st inside {ST_WAIT, ST_BIT_L, ST_ACK_L, ST_STOP_L};
    strb.sdaLow  = ((st inside {ST_ACK_L, ST_ACK_H}) && !nack) ||
                   (st inside {ST_STOP_L, ST_STOP_H});
  end

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL: regRdata = {4'b0, nack, hold, transmit, master};
      ADDR_STAT: regRdata = {4'b0, txEmpty, txEnd, stopDone, rxFull};
      ADDR_DATA: regRdata = rxByte;
      default:   regRdata = {7'b0, busy};
    endcase
  end

  // R7
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    capture |-> !rxFull);
  // R7
  hold_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_WAIT && rxFull) |=> (st != ST_BIT_L));
  // R2
  rxmode_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxMode) |-> (!txEnd && !txEmpty));
endmodule

// File: rtl/i2c_rx_dp.sv
module i2c_rx_dp
  import i2c_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  lineStrb_t         strb,
  input  logic              sdaIn,
  output logic [BYTE_W-1:0] rxByte,
  output logic              sclO,
  output logic              sdaO
);
  logic [BYTE_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxByte   <= '0;
    end else begin
      if (strb.shiftEn) shiftReg <= {shiftReg[BYTE_W-2:0], sdaIn};
      if (strb.capture) rxByte   <= {shiftReg[BYTE_W-2:0], sdaIn};
    end
  end

  assign sclO = !strb.sclLow;
  assign sdaO = !strb.sdaLow;

  // R9
  stop_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclO && $rose(sdaO)) |-> $past(sclO));
endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx
  import i2c_rx_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic        regRe,
  input  logic [1:0]  regAddr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  input  logic        sdaIn,
  output logic        sclO,
  output logic        sdaO
);
  lineStrb_t strb;
  logic [BYTE_W-1:0] rxByte;

  i2c_rx_ctrl #(.HALF_DIV(HALF_DIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata), .rxByte(rxByte),
    .regRdata(regRdata), .strb(strb)
  );

  i2c_rx_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaIn(sdaIn),
    .rxByte(rxByte), .sclO(sclO), .sdaO(sdaO)
  );
endmodule

// File: tb/i2c_byte_rx_tb_top.sv
`timescale 1ns/1ps
module i2c_byte_rx_tb_top;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0, regRe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic sclO, sdaO, sdaIn;

  int errCnt = 0, chkCnt = 0;
  logic [7:0] slaveBytes [5];
  int byteIdx = 0, rc = 0, sclRises = 0, sclHighCnt = 0, stopSetup = 0;
  logic presentBit = 1'b1, ackSeen = 1'b1, stopSeen = 1'b0;
  logic sclPrev = 1'b1, sdaPrev = 1'b1;

  always #2.5 clk = ~clk;

  assign sdaIn = sdaO & presentBit;

  i2c_byte_rx #(.HALF_DIV(H)) dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sdaIn(sdaIn), .sclO(sclO), .sdaO(sdaO)
  );

  // slave model and line monitor, updated away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (sclO && !sclPrev) begin
        sclRises++;
        if (rc == 8) ackSeen = sdaO;
        rc++;
        if (rc == 9) begin rc = 0; if (byteIdx < 4) byteIdx++; end
      end
      if (!sclO && sclPrev) presentBit = (rc < 8) ? slaveBytes[byteIdx][7-rc] : 1'b1;
      sclHighCnt = sclO ? (sclPrev ? sclHighCnt + 1 : 1) : 0;
      if (sclO && sclPrev && sdaO && !sdaPrev) begin
        stopSeen = 1'b1; stopSetup = sclHighCnt - 1; rc = 0;
      end
      sclPrev = sclO; sdaPrev = sdaO;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regRe = 1'b1; regAddr = a; #1 d = regRdata;
    @(negedge clk); regRe = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    regAddr = a; #1 d = regRdata;
  endtask

  // waits for byte-ready, returns negedges counted, then lets the ack clock finish
  task automatic waitFull(output int n);
    logic [7:0] s;
    n = 0;
    do begin @(negedge clk); peek(2'd1, s); n++; end while (!s[0] && n < 2000);
    repeat (2*H + 2) @(negedge clk);
  endtask

  task automatic waitStop();
    logic [7:0] s;
    int n = 0;
    do begin @(negedge clk); peek(2'd1, s); n++; end while (!s[1] && n < 2000);
  endtask

  task automatic testReset();
    logic [7:0] d;
    peek(2'd1, d); check("R1 status", d, 8'h0C);
    peek(2'd0, d); check("R1 control", d, 8'h00);
    peek(2'd3, d); check("R1 bus", d, 8'h00);
    check("R1 lines", {sclO, sdaO}, 2'b11);
  endtask

  task automatic testMultiByte();
    logic [7:0] d;
    int n, base;
    regWrite(2'd0, 8'h01);
    peek(2'd1, d); check("R2 tx flags cleared", d[3:2], 2'b00);
    peek(2'd3, d); check("R2 busy set", d[0], 1);
    repeat (20) @(negedge clk);
    check("R3 no clock before dummy read", sclRises, 0);
    check("R3 scl held low", sclO, 0);
    regRead(2'd2, d);                         // dummy read
    waitFull(n);
    check("R4 latency", n, 16*H + 1);
    check("R5 ack low", ackSeen, 0);
    regRead(2'd2, d); check("R4 data msb first", d, 8'hA5);
    peek(2'd1, d); check("R6 read clears ready", d[0], 0);
    // collision: read sampled on the capture edge of byte 2
    repeat (16*H - 1) @(negedge clk);
    regRead(2'd2, d); check("R11 old byte returned", d, 8'hA5);
    peek(2'd1, d); check("R11 ready stays set", d[0], 1);
    repeat (100) @(negedge clk);
    check("R7 scl stalls while unread", sclRises, 18);
    check("R11 no extra byte", sclO, 0);
    regRead(2'd2, d); check("R6 second byte", d, 8'h3C);
    waitFull(n);
    check("R6 read starts next byte", sclRises, 27);
    regWrite(2'd0, 8'h0D);                    // hold + nack
    regRead(2'd2, d); check("R4 third byte", d, 8'hF0);
    waitFull(n);
    check("R5 nack released", ackSeen, 1);
    regRead(2'd2, d); check("R8 last byte", d, 8'h81);
    base = sclRises;
    repeat (100) @(negedge clk);
    check("R8 no clock after final byte", sclRises - base, 0);
    peek(2'd1, d); check("R8 ready clear", d[0], 0);
    regWrite(2'd1, 8'h02);
    regWrite(2'd3, 8'h00);
    waitStop();
    check("R9 stop seen", stopSeen, 1);
    check("R9 setup time", (stopSetup >= H) ? 1 : 0, 1);
    peek(2'd3, d); check("R9 busy cleared", d[0], 0);
    check("R9 lines released", {sclO, sdaO}, 2'b11);
    regWrite(2'd1, 8'h02);
    peek(2'd1, d); check("R10 stop flag cleared", d[1], 0);
    regWrite(2'd0, 8'h00);
    peek(2'd0, d); check("R13 control cleared", d, 8'h00);
    check("R13 lines released", {sclO, sdaO}, 2'b11);
  endtask

  task automatic testSingleByte();
    logic [7:0] d;
    int n, base;
    stopSeen = 1'b0;
    regWrite(2'd0, 8'h0D);
    base = sclRises;
    regRead(2'd2, d);                         // dummy read
    waitFull(n);
    check("R12 nack on single byte", ackSeen, 1);
    repeat (60) @(negedge clk);
    check("R12 exactly one byte", sclRises - base, 9);
    regWrite(2'd3, 8'h00);
    waitStop();
    check("R12 stop done", stopSeen, 1);
    regRead(2'd2, d); check("R12 single data", d, 8'h5A);
    regWrite(2'd0, 8'h00);
    check("R13 idle after single", {sclO, sdaO}, 2'b11);
  endtask

  initial begin
    slaveBytes[0] = 8'hA5; slaveBytes[1] = 8'h3C; slaveBytes[2] = 8'hF0;
    slaveBytes[3] = 8'h81; slaveBytes[4] = 8'h5A;
    presentBit = slaveBytes[0][7];
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMultiByte();
    testSingleByte();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errCnt++; chkCnt++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule